// File: doc/BRIEF.md
# TDM Audio Slot Serializer

This block sends audio words out one bit per clock on a single serial line organised as time-division-multiplexed frames. A frame holds a programmable number of slots, and each slot is a 32-bit container. Before a word goes onto the line, it is shaped in three steps. A 32-bit mask clears unwanted bits. A rotate field turns the word right in 4-bit steps. A slot-size code decides how many leading bits of the container carry the word; the rest of the slot is zero padding. The bit order is also selectable, so the word can leave most significant bit first or least significant bit first.

A per-slot enable vector picks which slots carry samples. Silent slots drive zeros and consume nothing. Words come from a one-word holding register that is loaded through a valid/ready handshake. An internal frame sync generator marks the frame start. The sync is either one bit wide or lasts one slot, and its polarity is selectable. It is asserted during the last bit of the previous frame, so the first data bit follows with no gap.

All configuration inputs are sampled only at a frame boundary. The `run` input starts and stops the frame stream.

Top module: `tdm_tx_serializer`

## Requirements
- R1: During and directly after a synchronous reset, `ser_out` is 0, `fs_out` is 0, `underrun` is 0 and `in_ready` is 1.
- R2: The word sent in a slot is `rotr(in_word & cfg_mask, 4*cfg_fmt[2:0])`, a 32-bit rotate right.
- R3: With `cfg_fmt[15]`=1 the rotated word leaves bit 31 first and bit 0 last. With `cfg_fmt[15]`=0 it leaves bit 0 first.
- R4: Slot-size code `cfg_fmt[7:4]`: the odd codes 3 to 15 send the first 2*(code+1) serial bits of the slot (8 to 32) and drive 0 for the rest of the 32-bit slot. Any other code sends all 32 bits.
- R5: `cfg_frame[15:7]` gives the number of slots per frame, and a frame lasts 32 bits per slot. A value below 2 acts as 2, and a value above 32 acts as 32.
- R6: Slot s is active when `cfg_slot_en[s]`=1. An inactive slot drives 0 for all of its bits and takes no word from the holding register.
- R7: The internal sync is active during the last bit of every frame that is followed by another frame. With `cfg_frame[4]`=0 it is active for that one bit only.
- R8: With `cfg_frame[4]`=1 the sync stays active for the last bit of the previous frame and for bits 0 to 30 of slot 0, which is 32 bits in all.
- R9: `fs_out` equals the active-sync value AND `cfg_frame[1]`, XOR `cfg_frame[0]`. So bit 0 set inverts the line, and bit 1 clear holds the line at its inactive level.
- R10: `in_ready` is 1 exactly when the holding register is empty. A word is accepted on a clock edge where `in_valid` and `in_ready` are both 1, and it is removed at the first bit of the next active slot.
- R11: If an active slot starts while the holding register is empty, the slot drives zeros and `underrun` becomes 1. It stays 1 until reset.
- R12: The configuration inputs are captured only on the edge that presents the last bit of a frame, or the lead bit. Changes made mid-frame do not affect the frame in progress.
- R13: While idle, `ser_out` is 0 and the sync is inactive. When `run` is 1 in idle, one lead bit (data 0, sync active) is sent and then frame bit 0 follows. When `run` is 0 during a frame's last bit, that bit carries no sync and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Start/continue the frame stream |
| cfg_fmt | input | 16 | Word format: [15] MSB first, [7:4] slot-size code, [2:0] rotate |
| cfg_frame | input | 16 | Frame control: [15:7] slot count, [4] slot-long sync, [1] sync generation on, [0] sync inverted |
| cfg_mask | input | SLOT_BITS | Data bit mask |
| cfg_slot_en | input | MAX_SLOTS | Per-slot active mask |
| in_data | input | SLOT_BITS | Word to send |
| in_valid | input | 1 | Word valid |
| in_ready | output | 1 | Holding register empty |
| ser_out | output | 1 | Serial data |
| fs_out | output | 1 | Frame sync |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The bench builds the block with its default parameters: 32-bit slots and up to 32 slots per frame. With these values the slot-count clamp at both ends can be reached, including the full 1024-bit frame, and every rotate and size code maps onto the real 32-bit container. The test feeder can run back-to-back or be throttled, which drives the holding register into both the always-full and the starved conditions. Configuration is also rewritten mid-frame, which exercises the frame-boundary capture.

// File: rtl/tdm_ser_pkg.sv
package tdm_ser_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  typedef struct packed {
    logic       msb_first;
    logic [3:0] size_code;
    logic [2:0] rot;
    logic       dur_word;
    logic       pol_inv;
    logic       gen_en;
  } fmt_cfg_t;

  // Odd codes from 3 upward give 2*(code+1) bits; anything else is the full slot.
  function automatic int unsigned size_to_len(input logic [3:0] code,
                                              input int unsigned slot_bits);
    int unsigned len;
    if (code[0] && (code >= 4'd3)) len = 2 * (int'(code) + 1);
    else len = slot_bits;
    if (len > slot_bits) len = slot_bits;
    return len;
  endfunction

endpackage

// File: rtl/tdm_word_fmt.sv
module tdm_word_fmt #(
  parameter int unsigned SLOT_BITS = 32,
  parameter int unsigned ROT_UNIT  = 4,
  parameter int unsigned LEN_W     = $clog2(SLOT_BITS + 1)
) (
  input  logic [SLOT_BITS-1:0] data_i,
  input  logic [SLOT_BITS-1:0] mask_i,
  input  logic [2:0]           rot_i,
  input  logic                 msb_first_i,
  input  logic [LEN_W-1:0]     len_i,
  output logic [SLOT_BITS-1:0] bits_o
);
  localparam int unsigned SH_W = $clog2(2 * SLOT_BITS);

  logic [SLOT_BITS-1:0]   masked;
  logic [SLOT_BITS-1:0]   rotated;
  logic [2*SLOT_BITS-1:0] doubled;
  logic [SH_W-1:0]        amount;

  always_comb begin
    masked  = data_i & mask_i;
    amount  = SH_W'(rot_i) * SH_W'(ROT_UNIT);
    doubled = {masked, masked} >> amount;
    rotated = doubled[SLOT_BITS-1:0];
  end

  // bits_o[i] is the i-th bit placed on the line within the slot.
  generate
    for (genvar i = 0; i < SLOT_BITS; i++) begin : g_order
      logic picked;
      assign picked    = msb_first_i ? rotated[SLOT_BITS-1-i] : rotated[i];
      assign bits_o[i] = (LEN_W'(i) < len_i) ? picked : 1'b0;
    end
  endgenerate

endmodule

// File: rtl/tdm_hold.sv
module tdm_hold #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         take_i,
  output logic         full_o,
  output logic [W-1:0] word_o
);
  logic         full_q;
  logic [W-1:0] word_q;
  logic         accept;

  assign accept   = in_valid && !full_q;
  assign in_ready = !full_q;
  assign full_o   = full_q;
  assign word_o   = word_q;

  always_ff @(posedge clk) begin
    if (rst)         full_q <= 1'b0;
    else if (take_i) full_q <= 1'b0;
    else if (accept) full_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (accept) word_q <= in_data;
  end

  assert_hold_keeps_R10: assert property (@(posedge clk) disable iff (rst)
    (full_q && !take_i) |=> (full_q && $stable(word_q)))
    else $error("holding word lost without being taken");

  assert_take_empties_R10: assert property (@(posedge clk) disable iff (rst)
    take_i |=> !full_q)
    else $error("holding register still full after take");

endmodule

// File: rtl/tdm_frame_seq.sv
module tdm_frame_seq
  import tdm_ser_pkg::*;
#(
  parameter int unsigned SLOT_BITS = 32,
  parameter int unsigned MAX_SLOTS = 32,
  parameter int unsigned BIT_W     = $clog2(SLOT_BITS),
  parameter int unsigned SLOT_W    = $clog2(MAX_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run_i,
  input  fmt_cfg_t             fmt_i,
  input  logic [SLOT_W-1:0]    last_slot_i,
  input  logic [SLOT_BITS-1:0] mask_i,
  input  logic [MAX_SLOTS-1:0] en_i,
  output fmt_cfg_t             fmt_o,
  output logic [SLOT_BITS-1:0] mask_o,
  output logic [MAX_SLOTS-1:0] en_o,
  output logic                 running_o,
  output logic [SLOT_W-1:0]    slot_o,
  output logic                 slot_start_o,
  output logic                 fs_act_o,
  output logic                 pol_o,
  output logic                 gen_o
);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(SLOT_BITS - 1);

  seq_state_e           state_q;
  logic [SLOT_W-1:0]    slot_q;
  logic [BIT_W-1:0]     bit_q;
  fmt_cfg_t             fmt_q;
  logic [SLOT_W-1:0]    last_q;
  logic [SLOT_BITS-1:0] mask_q;
  logic [MAX_SLOTS-1:0] en_q;

  logic at_end;
  logic use_new;
  logic latch_en;

  always_comb begin
    at_end   = (state_q == ST_RUN) && (slot_q == last_q) && (bit_q == BIT_LAST);
    use_new  = (state_q == ST_IDLE) || at_end;
    latch_en = use_new && run_i;
    if (use_new) fs_act_o = run_i;
    else         fs_act_o = fmt_q.dur_word && (slot_q == '0) && (bit_q != BIT_LAST);
    pol_o        = use_new ? fmt_i.pol_inv : fmt_q.pol_inv;
    gen_o        = use_new ? fmt_i.gen_en  : fmt_q.gen_en;
    running_o    = (state_q == ST_RUN);
    slot_start_o = (state_q == ST_RUN) && (bit_q == '0);
  end

  assign slot_o = slot_q;
  assign fmt_o  = fmt_q;
  assign mask_o = mask_q;
  assign en_o   = en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      bit_q   <= '0;
    end else if (latch_en) begin
      state_q <= ST_RUN;
      slot_q  <= '0;
      bit_q   <= '0;
    end else if (at_end) begin
      state_q <= ST_IDLE;
    end else if (state_q == ST_RUN) begin
      if (bit_q == BIT_LAST) begin
        bit_q  <= '0;
        slot_q <= slot_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q  <= '0;
      last_q <= '0;
      mask_q <= '0;
      en_q   <= '0;
    end else if (latch_en) begin
      fmt_q  <= fmt_i;
      last_q <= last_slot_i;
      mask_q <= mask_i;
      en_q   <= en_i;
    end
  end

  assert_slot_range_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN) |-> (slot_q <= last_q))
    else $error("slot index beyond frame length");

  assert_cfg_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !latch_en |=> ($stable(en_q) && $stable(mask_q) && $stable(fmt_q) && $stable(last_q)))
    else $error("configuration changed away from a frame boundary");

endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer
  import tdm_ser_pkg::*;
#(
  parameter int unsigned SLOT_BITS = 32,
  parameter int unsigned MAX_SLOTS = 32,
  parameter int unsigned ROT_UNIT  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic [15:0]          cfg_fmt,
  input  logic [15:0]          cfg_frame,
  input  logic [SLOT_BITS-1:0] cfg_mask,
  input  logic [MAX_SLOTS-1:0] cfg_slot_en,
  input  logic [SLOT_BITS-1:0] in_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  output logic                 ser_out,
  output logic                 fs_out,
  output logic                 underrun
);
  localparam int unsigned SLOT_W = $clog2(MAX_SLOTS);
  localparam int unsigned LEN_W  = $clog2(SLOT_BITS + 1);

  fmt_cfg_t             fmt_in;
  fmt_cfg_t             act_fmt;
  logic [8:0]           slot_field;
  logic [SLOT_W-1:0]    last_slot_in;
  logic [SLOT_BITS-1:0] act_mask;
  logic [MAX_SLOTS-1:0] act_en;
  logic                 running;
  logic [SLOT_W-1:0]    cur_slot;
  logic                 slot_start;
  logic                 fs_act;
  logic                 pol;
  logic                 gen;
  logic                 hold_full;
  logic [SLOT_BITS-1:0] hold_word;
  logic [SLOT_BITS-1:0] fmt_bits;
  logic [LEN_W-1:0]     word_len;
  logic                 act_slot;
  logic                 take;

  logic                 ser_q;
  logic                 fs_q;
  logic                 fs_act_q;
  logic                 under_q;
  logic [SLOT_BITS-1:0] sh_q;

  always_comb begin
    fmt_in.msb_first = cfg_fmt[15];
    fmt_in.size_code = cfg_fmt[7:4];
    fmt_in.rot       = cfg_fmt[2:0];
    fmt_in.dur_word  = cfg_frame[4];
    fmt_in.pol_inv   = cfg_frame[0];
    fmt_in.gen_en    = cfg_frame[1];
    slot_field       = cfg_frame[15:7];
    if (slot_field < 9'd2)                   last_slot_in = SLOT_W'(1);
    else if (slot_field > 9'(MAX_SLOTS))     last_slot_in = SLOT_W'(MAX_SLOTS - 1);
    else                                     last_slot_in = SLOT_W'(slot_field - 9'd1);
  end

  tdm_frame_seq #(
    .SLOT_BITS(SLOT_BITS),
    .MAX_SLOTS(MAX_SLOTS)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .run_i       (run),
    .fmt_i       (fmt_in),
    .last_slot_i (last_slot_in),
    .mask_i      (cfg_mask),
    .en_i        (cfg_slot_en),
    .fmt_o       (act_fmt),
    .mask_o      (act_mask),
    .en_o        (act_en),
    .running_o   (running),
    .slot_o      (cur_slot),
    .slot_start_o(slot_start),
    .fs_act_o    (fs_act),
    .pol_o       (pol),
    .gen_o       (gen)
  );

  assign act_slot = act_en[cur_slot];
  assign take     = slot_start && act_slot && hold_full;

  tdm_hold #(
    .W(SLOT_BITS)
  ) u_hold (
    .clk     (clk),
    .rst     (rst),
    .in_data (in_data),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .take_i  (take),
    .full_o  (hold_full),
    .word_o  (hold_word)
  );

  assign word_len = LEN_W'(size_to_len(act_fmt.size_code, SLOT_BITS));

  tdm_word_fmt #(
    .SLOT_BITS(SLOT_BITS),
    .ROT_UNIT (ROT_UNIT),
    .LEN_W    (LEN_W)
  ) u_fmt (
    .data_i     (hold_word),
    .mask_i     (act_mask),
    .rot_i      (act_fmt.rot),
    .msb_first_i(act_fmt.msb_first),
    .len_i      (word_len),
    .bits_o     (fmt_bits)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_q    <= 1'b0;
      fs_q     <= 1'b0;
      fs_act_q <= 1'b0;
      under_q  <= 1'b0;
      sh_q     <= '0;
    end else begin
      fs_act_q <= fs_act;
      fs_q     <= (fs_act & gen) ^ pol;
      if (!running) begin
        ser_q <= 1'b0;
      end else if (slot_start) begin
        if (take) begin
          ser_q <= fmt_bits[0];
          sh_q  <= fmt_bits >> 1;
        end else begin
          ser_q <= 1'b0;
          sh_q  <= '0;
        end
        if (act_slot && !hold_full) under_q <= 1'b1;
      end else begin
        ser_q <= sh_q[0];
        sh_q  <= sh_q >> 1;
      end
    end
  end

  assign ser_out  = ser_q;
  assign fs_out   = fs_q;
  assign underrun = under_q;

  assert_silent_slot_R6: assert property (@(posedge clk) disable iff (rst)
    (slot_start && !act_slot) |=> !ser_out)
    else $error("inactive slot drove a one");

  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (rst)
    !running |=> !ser_out)
    else $error("data driven while idle");

  assert_underrun_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun)
    else $error("underrun flag cleared without reset");

  assert_sync_one_bit_R7: assert property (@(posedge clk) disable iff (rst)
    (fs_act_q && !act_fmt.dur_word) |=> !fs_act_q)
    else $error("one-bit sync lasted more than one bit");

endmodule

// File: tb/tdm_tx_serializer_bench.sv
module tdm_tx_serializer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic [15:0] cfg_fmt = 16'h80F0;
  logic [15:0] cfg_frame = 16'h0102;
  logic [31:0] cfg_mask = 32'hFFFF_FFFF;
  logic [31:0] cfg_slot_en = 32'hFFFF_FFFF;
  logic [31:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        ser_out;
  logic        fs_out;
  logic        underrun;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    cmp_on = 1'b0;
  bit    feed_on = 1'b0;
  int    slow_gap = 0;
  int    gap_cnt = 0;
  int    feed_cnt = 0;
  bit    last_rdy = 1'b0;

  always #5 clk = ~clk;

  tdm_tx_serializer u_tdm_tx_serializer (
    .clk(clk), .rst(rst), .run(run), .cfg_fmt(cfg_fmt), .cfg_frame(cfg_frame),
    .cfg_mask(cfg_mask), .cfg_slot_en(cfg_slot_en), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .ser_out(ser_out),
    .fs_out(fs_out), .underrun(underrun)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_state = 0;
  int          m_slot = 0;
  int          m_bit = 0;
  bit          m_full = 0;
  bit          m_under = 0;
  logic [31:0] m_hold = '0;
  logic [31:0] m_word = '0;
  logic [15:0] m_fmt = '0;
  logic [15:0] m_frm = '0;
  logic [31:0] m_mask = '0;
  logic [31:0] m_en = '0;
  bit          e_ser = 0;
  bit          e_fs = 0;

  function automatic logic [31:0] model_bits(input logic [31:0] d, input logic [31:0] mk,
                                             input logic [15:0] f);
    logic [31:0] m;
    logic [31:0] w;
    logic [31:0] r;
    int sh;
    int len;
    int code;
    m = d & mk;
    sh = 4 * int'(f[2:0]);
    w = (sh == 0) ? m : ((m >> sh) | (m << (32 - sh)));
    code = int'(f[7:4]);
    len = ((code % 2) == 1 && code >= 3) ? 2 * (code + 1) : 32;
    for (int i = 0; i < 32; i++)
      r[i] = (i < len) ? (f[15] ? w[31 - i] : w[i]) : 1'b0;
    return r;
  endfunction

  function automatic int clamp_slots(input logic [8:0] raw);
    if (raw < 2) return 2;
    if (raw > 32) return 32;
    return int'(raw);
  endfunction

  always @(posedge clk) begin
    bit acc;
    bit act;
    bit pol_u;
    bit gen_u;
    bit last;
    int nsl;
    acc = in_valid && !m_full;
    if (rst) begin
      m_state = 0; m_full = 0; m_under = 0; e_ser = 0; e_fs = 0;
      m_slot = 0; m_bit = 0;
    end else begin
      act = 0;
      if (m_state == 0) begin
        e_ser = 0;
        pol_u = cfg_frame[0];
        gen_u = cfg_frame[1];
        if (run) begin
          act = 1;
          m_fmt = cfg_fmt; m_frm = cfg_frame; m_mask = cfg_mask; m_en = cfg_slot_en;
          m_state = 1; m_slot = 0; m_bit = 0;
        end
      end else begin
        nsl = clamp_slots(m_frm[15:7]);
        last = (m_slot == nsl - 1) && (m_bit == 31);
        if (m_bit == 0) begin
          if (m_en[m_slot]) begin
            if (m_full) begin
              m_word = model_bits(m_hold, m_mask, m_fmt);
              m_full = 0;
            end else begin
              m_word = '0;
              m_under = 1;
            end
          end else begin
            m_word = '0;
          end
        end
        e_ser = m_word[m_bit];
        if (last) begin
          act = run;
          pol_u = cfg_frame[0];
          gen_u = cfg_frame[1];
          if (run) begin
            m_fmt = cfg_fmt; m_frm = cfg_frame; m_mask = cfg_mask; m_en = cfg_slot_en;
            m_slot = 0; m_bit = 0;
          end else begin
            m_state = 0;
          end
        end else begin
          act = m_frm[4] && (m_slot == 0) && (m_bit < 31);
          pol_u = m_frm[0];
          gen_u = m_frm[1];
          if (m_bit == 31) begin
            m_bit = 0;
            m_slot++;
          end else begin
            m_bit++;
          end
        end
      end
      e_fs = (act && gen_u) ^ pol_u;
      if (acc) begin
        m_full = 1;
        m_hold = in_data;
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (cmp_on) begin
      check(cur_req, "ser_out", {31'b0, ser_out}, {31'b0, e_ser});
      check(cur_req, "fs_out", {31'b0, fs_out}, {31'b0, e_fs});
      check(cur_req, "underrun R11", {31'b0, underrun}, {31'b0, m_under});
      check(cur_req, "in_ready R10", {31'b0, in_ready}, {31'b0, !m_full});
    end
  end

  // ---------------- word feeder ----------------
  always @(negedge clk) begin
    if (in_valid && last_rdy) begin
      feed_cnt++;
      gap_cnt = 0;
    end else begin
      gap_cnt++;
    end
    last_rdy = in_ready;
    in_data  = (32'(feed_cnt) + 32'd1) * 32'h9E37_79B1;
    in_valid = feed_on && (gap_cnt >= slow_gap);
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R13 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    wait_cycles(3);
    check("R1", "ser_out", {31'b0, ser_out}, 32'd0);
    check("R1", "fs_out", {31'b0, fs_out}, 32'd0);
    check("R1", "underrun", {31'b0, underrun}, 32'd0);
    check("R1", "in_ready", {31'b0, in_ready}, 32'd1);
    rst = 1'b0;
    cmp_on = 1'b1;

    // R10: word accepted while idle, ready drops and stays low
    cur_req = "R10";
    feed_on = 1'b1;
    wait_cycles(4);
    check("R10", "in_ready held low", {31'b0, in_ready}, 32'd0);

    // R7: 32-bit MSB-first, 2 slots, one-bit sync
    cur_req = "R7";
    run = 1'b1;
    wait_cycles(200);

    // R2: 16-bit data rotated into top, changed mid-frame
    cur_req = "R2";
    cfg_fmt = 16'h8074; cfg_mask = 32'h0000_FFFF;
    wait_cycles(200);

    // R3: LSB first, 24-bit code, rotate 2
    cur_req = "R3";
    cfg_fmt = 16'h00B2; cfg_mask = 32'h00FF_FFFF;
    wait_cycles(200);

    // R6 / R8 / R9: 8 slots, sparse enables, slot-long inverted sync
    cur_req = "R6";
    cfg_fmt = 16'h80F0; cfg_mask = 32'hFFFF_FFFF;
    cfg_frame = 16'h0413; cfg_slot_en = 32'h0000_005A;
    wait_cycles(400);
    cur_req = "R8";
    wait_cycles(400);

    // R4 and R5 lower clamp: slot count 1, even size code
    cur_req = "R4";
    cfg_fmt = 16'h8041; cfg_frame = 16'h0082; cfg_slot_en = 32'hFFFF_FFFF;
    wait_cycles(200);
    cfg_fmt = 16'h0051;
    wait_cycles(150);

    // R5 upper clamp: slot count 40 acts as 32
    cur_req = "R5";
    cfg_fmt = 16'h80F0; cfg_frame = 16'h1402;
    wait_cycles(2200);

    // R9: generation off, inverted polarity
    cur_req = "R9";
    cfg_frame = 16'h0101;
    wait_cycles(300);

    // R12: slot count changed mid-frame, back and forth
    cur_req = "R12";
    cfg_frame = 16'h0202;
    wait_cycles(37);
    cfg_frame = 16'h0102;
    wait_cycles(11);
    cfg_slot_en = 32'h0000_0002;
    wait_cycles(300);
    cfg_slot_en = 32'hFFFF_FFFF;

    // R11: starved feeder
    cur_req = "R11";
    slow_gap = 50;
    wait_cycles(600);
    check("R11", "underrun sticky", {31'b0, underrun}, 32'd1);
    slow_gap = 0;
    wait_cycles(200);
    check("R11", "underrun still set", {31'b0, underrun}, 32'd1);

    // R13: stop mid-frame, idle, restart
    cur_req = "R13";
    wait_cycles(20);
    run = 1'b0;
    wait_cycles(150);
    check("R13", "idle ser_out", {31'b0, ser_out}, 32'd0);
    check("R13", "idle fs_out", {31'b0, fs_out}, 32'd0);
    run = 1'b1;
    wait_cycles(150);

    cmp_on = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule